// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block brings one instruction word from a memory into an instruction register through three fixed register-transfer steps, then hands control to an execute stage and waits. It holds the program counter, a memory address register, a memory data register and the instruction register. It also holds the input multiplexers that feed the address register and the program counter, and a four-state sequencer. Each state decodes into one row of load enables and multiplexer selects. All registers share one rising-edge clock, and every load is a synchronous clock enable.

The memory side is a plain combinational read port. The address output follows the memory address register. The memory must return the addressed word on the data input in the same cycle that the data register is loaded.

The execute side sees a busy flag for as long as the sequencer sits in its execute state. The execute stage raises a done input to release the next fetch. It can also redirect the program counter to a branch target in that same cycle.

Top module: `fetch_seq`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the address register, the data register and the instruction register to 0. It puts the sequencer in the load-address state, whose code on `state` is 1.
- R2: The state codes are 0 = execute, 1 = load address, 2 = load data and count, 3 = load instruction. The order is 1 → 2 → 3 → 0 → 1, and each fetch step lasts exactly one cycle.
- R3: In state 1 only `ld_mar` is high and `mar_sel` is 0, so the address register takes the program counter. `mem_addr` shows that value from the next cycle.
- R4: In state 2, `ld_mdr` and `ld_pc` are high, `ld_mar` and `ld_ir` are low, and `pc_sel` is 0. The data register captures `mem_rdata` and the program counter advances by one, both on the same edge.
- R5: In state 3 only `ld_ir` is high, and the instruction register takes the data register contents. `ir` shows the word read at the fetched address.
- R6: In state 0 `exec_busy` is high. The sequencer stays in state 0 while `exec_done` is low, and during that time no register is loaded, so `pc`, `ir` and `mem_addr` hold.
- R7: In state 0 with both `exec_done` and `jump_en` high, `ld_pc` and `pc_sel` are high and the program counter loads `jump_target`. The next fetch then uses that address. `jump_en` has no effect while `exec_done` is low.
- R8: The program counter increment wraps from the all-ones address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_done | input | 1 | Execute stage finished; release the next fetch |
| jump_en | input | 1 | With exec_done, load jump_target into the program counter |
| jump_target | input | ADDR_W | Branch destination address |
| mem_rdata | input | DATA_W | Combinational read data for mem_addr |
| mem_addr | output | ADDR_W | Memory address, driven by the address register |
| pc | output | ADDR_W | Current program counter |
| ir | output | DATA_W | Fetched instruction word |
| state | output | 2 | Sequencer state code |
| exec_busy | output | 1 | High while in the execute state |
| ld_mar | output | 1 | Address register load enable |
| ld_mdr | output | 1 | Data register load enable |
| ld_ir | output | 1 | Instruction register load enable |
| ld_pc | output | 1 | Program counter load enable |
| mar_sel | output | 1 | Address register source: 0 program counter, 1 jump target |
| pc_sel | output | 1 | Program counter source: 0 incrementer, 1 jump target |

## Verification
The hardest case to reach from the ports is the counter wrapping from the top address. Sequential fetches would need hundreds of instructions to get there. The stimulus instead ends an execute phase with a branch to the all-ones address, fetches once from there, and checks that the counter reads 0 and that the following fetch addresses location 0. Long execute phases also hold `jump_en` high while `exec_done` is low, to show that the counter, the address and the instruction stay put until release.

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_done,
  input  logic              jump_en,
  input  logic [ADDR_W-1:0] jump_target,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [1:0]        state,
  output logic              exec_busy,
  output logic              ld_mar,
  output logic              ld_mdr,
  output logic              ld_ir,
  output logic              ld_pc,
  output logic              mar_sel,
  output logic              pc_sel
);

  typedef enum logic [1:0] {
    S_EXEC = 2'd0,
    S_LMAR = 2'd1,
    S_LMDR = 2'd2,
    S_LIR  = 2'd3
  } st_t;

  st_t               cur, nxt;
  logic [ADDR_W-1:0] mar_q, pc_q, pc_inc, mar_d, pc_d;
  logic [DATA_W-1:0] mdr_q, ir_q;

  always_comb begin
    ld_mar  = 1'b0;
    ld_mdr  = 1'b0;
    ld_ir   = 1'b0;
    ld_pc   = 1'b0;
    mar_sel = 1'b0;
    pc_sel  = 1'b0;
    nxt     = cur;
    case (cur)
      S_EXEC: begin
        if (exec_done) begin
          nxt    = S_LMAR;
          ld_pc  = jump_en;
          pc_sel = jump_en;
        end
      end
      S_LMAR: begin
        ld_mar = 1'b1;
        nxt    = S_LMDR;
      end
      S_LMDR: begin
        ld_mdr = 1'b1;
        ld_pc  = 1'b1;
        nxt    = S_LIR;
      end
      default: begin
        ld_ir = 1'b1;
        nxt   = S_EXEC;
      end
    endcase
  end

  assign pc_inc = pc_q + 1'b1;
  assign mar_d  = mar_sel ? jump_target : pc_q;
  assign pc_d   = pc_sel  ? jump_target : pc_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= S_LMAR;
      mar_q <= '0;
      pc_q  <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
    end else begin
      cur <= nxt;
      if (ld_mar) mar_q <= mar_d;
      if (ld_mdr) mdr_q <= mem_rdata;
      if (ld_pc)  pc_q  <= pc_d;
      if (ld_ir)  ir_q  <= mdr_q;
    end
  end

  assign mem_addr  = mar_q;
  assign pc        = pc_q;
  assign ir        = ir_q;
  assign state     = cur;
  assign exec_busy = (cur == S_EXEC);

  a_r2_lmar_to_lmdr: assert property (@(posedge clk) disable iff (rst)
    cur == S_LMAR |=> cur == S_LMDR);
  a_r2_lmdr_to_lir: assert property (@(posedge clk) disable iff (rst)
    cur == S_LMDR |=> cur == S_LIR);
  a_r2_lir_to_exec: assert property (@(posedge clk) disable iff (rst)
    cur == S_LIR |=> cur == S_EXEC);
  a_r3_mar_from_pc: assert property (@(posedge clk) disable iff (rst)
    cur == S_LMAR |=> mar_q == $past(pc_q));
  a_r4_pc_counts: assert property (@(posedge clk) disable iff (rst)
    cur == S_LMDR |=> pc_q == $past(pc_q) + 1'b1 && mdr_q == $past(mem_rdata));
  a_r5_ir_from_mdr: assert property (@(posedge clk) disable iff (rst)
    cur == S_LIR |=> ir_q == $past(mdr_q));
  a_r6_exec_holds: assert property (@(posedge clk) disable iff (rst)
    cur == S_EXEC && !exec_done |=> cur == S_EXEC && $stable(pc_q) && $stable(mar_q) && $stable(ir_q));
  a_r6_fetch_regs_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_mar, ld_mdr, ld_ir}));
  a_r7_jump_taken: assert property (@(posedge clk) disable iff (rst)
    cur == S_EXEC && exec_done && jump_en |=> pc_q == $past(jump_target) && cur == S_LMAR);

endmodule

// File: tb/tb_fetch_seq.sv
module tb_fetch_seq;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          exec_done = 1'b0;
  logic          jump_en = 1'b0;
  logic [AW-1:0] jump_target = '0;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr, pc;
  logic [DW-1:0] ir;
  logic [1:0]    state;
  logic          exec_busy, ld_mar, ld_mdr, ld_ir, ld_pc, mar_sel, pc_sel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  logic [AW-1:0] exp_pc;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] memword(input logic [AW-1:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  assign mem_rdata = memword(mem_addr);

  fetch_seq #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .exec_done(exec_done), .jump_en(jump_en),
    .jump_target(jump_target), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .pc(pc), .ir(ir), .state(state), .exec_busy(exec_busy), .ld_mar(ld_mar),
    .ld_mdr(ld_mdr), .ld_ir(ld_ir), .ld_pc(ld_pc), .mar_sel(mar_sel), .pc_sel(pc_sel)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(); tick();
    chk(state == 2'd1, "R1 state", 32'(state), 1);
    chk(pc == 0 && mem_addr == 0 && ir == 0, "R1 regs", {8'(pc), 8'(mem_addr), 16'(ir)}, 0);
    rst = 1'b0;
    exp_pc = '0;
  endtask

  task automatic do_fetch();
    logic [AW-1:0] p;
    p = exp_pc;
    chk(state == 2'd1, "R2 in load-address", 32'(state), 1);
    chk({ld_mar, ld_mdr, ld_ir, ld_pc, mar_sel} == 5'b10000, "R3 enables",
        32'({ld_mar, ld_mdr, ld_ir, ld_pc, mar_sel}), 32'b10000);
    tick();
    chk(state == 2'd2, "R2 to load-data", 32'(state), 2);
    chk(mem_addr == p, "R3 mem_addr", 32'(mem_addr), 32'(p));
    chk({ld_mar, ld_mdr, ld_ir, ld_pc, pc_sel} == 5'b01010, "R4 enables",
        32'({ld_mar, ld_mdr, ld_ir, ld_pc, pc_sel}), 32'b01010);
    tick();
    exp_pc = p + 1'b1;
    chk(state == 2'd3, "R2 to load-instr", 32'(state), 3);
    chk(pc == exp_pc, "R4 pc advance", 32'(pc), 32'(exp_pc));
    chk({ld_mar, ld_mdr, ld_ir, ld_pc} == 4'b0010, "R5 enables",
        32'({ld_mar, ld_mdr, ld_ir, ld_pc}), 32'b0010);
    tick();
    chk(state == 2'd0 && exec_busy, "R2 to execute", 32'({exec_busy, state}), 32'b100);
    chk(ir == memword(p), "R5 ir word", 32'(ir), 32'(memword(p)));
  endtask

  task automatic do_exec(input int waits, input bit jmp, input logic [AW-1:0] tgt);
    logic [DW-1:0] ir0;
    logic [AW-1:0] a0;
    ir0 = ir;
    a0 = mem_addr;
    jump_en = 1'b1;
    jump_target = tgt;
    for (int i = 0; i < waits; i++) begin
      chk({ld_mar, ld_mdr, ld_ir, ld_pc} == 0, "R6 no enables", 32'({ld_mar, ld_mdr, ld_ir, ld_pc}), 0);
      tick();
      chk(state == 2'd0, "R6 waits", 32'(state), 0);
      chk(pc == exp_pc && ir == ir0 && mem_addr == a0, "R7 jump_en ignored / R6 hold",
          {8'(pc), 16'(ir), 8'(mem_addr)}, {8'(exp_pc), 16'(ir0), 8'(a0)});
    end
    jump_en = jmp;
    exec_done = 1'b1;
    #0.1;
    if (jmp) chk(ld_pc && pc_sel, "R7 jump select", 32'({ld_pc, pc_sel}), 3);
    else chk(!ld_pc, "R6 no pc load", 32'(ld_pc), 0);
    tick();
    exec_done = 1'b0;
    jump_en = 1'b0;
    if (jmp) exp_pc = tgt;
    chk(state == 2'd1, "R6 release", 32'(state), 1);
    chk(pc == exp_pc, "R7 pc after execute", 32'(pc), 32'(exp_pc));
  endtask

  task automatic test_sequential();
    for (int k = 0; k < 4; k++) begin
      do_fetch();
      do_exec(k, 1'b0, 8'h00);
    end
  endtask

  task automatic test_jump();
    do_fetch();
    do_exec(2, 1'b1, 8'h40);
    do_fetch();
    chk(ir == memword(8'h40), "R7 fetch at target", 32'(ir), 32'(memword(8'h40)));
    do_exec(0, 1'b0, 8'h00);
  endtask

  task automatic test_wrap();
    do_fetch();
    do_exec(1, 1'b1, 8'hFF);
    do_fetch();
    chk(pc == 0, "R8 wrap to zero", 32'(pc), 0);
    do_exec(0, 1'b0, 8'h00);
    do_fetch();
    chk(ir == memword(8'h00), "R8 fetch after wrap", 32'(ir), 32'(memword(8'h00)));
    do_exec(0, 1'b0, 8'h00);
  endtask

  task automatic test_midreset();
    do_fetch();
    do_exec(0, 1'b0, 8'h00);
    tick();
    do_reset();
    do_fetch();
    chk(ir == memword(8'h00), "R1 restart fetch", 32'(ir), 32'(memword(8'h00)));
  endtask

  initial begin
    do_reset();
    test_sequential();
    test_jump();
    test_wrap();
    test_midreset();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule